// File: doc/BRIEF.md
# Nibble Line-Code Transmitter with Pseudo-Random Test Source

This block is the transmit end of a serial link. An upstream scheduler hands it one symbol at a time: a 4-bit data nibble, an idle fill, or a sync marker. The block turns each one into a 5-bit line-code group and shifts that group onto a single serial wire, one bit per clock, most significant bit first. The scheduler never picks the timing. The block raises a one-cycle request on the cycle in which it takes the next symbol, and the scheduler answers on that same cycle.

A sync request produces two code groups in a row, a first half and then a second half. The block inserts the second half by itself and makes no request for it. For compliance testing with no data source attached, a test input swaps the symbol stream for a 7-stage pseudo-random bit sequence. That sequence is cut into 5-bit groups and goes through the same shift stage. The test input is only acted on at a group boundary, so the line never carries a partial code group. The block is intended to run from a 125 MHz high-speed clock.

Top module: `nibble_line_tx`

## Requirements
- R1: While `rst_n` is low and on the cycle after its release, `ser_out` is 1 and `sym_req` is 0. The first group after reset is idle (five ones), and `sym_req` rises on the fifth bit of that group.
- R2: With `sym_kind` = 2'b00 (data), nibble 0..F maps to, in order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: Each code group is sent most significant bit first, one bit per clock. The group sampled at a request edge appears on `ser_out` during the next five cycles.
- R4: `sym_kind` = 2'b01 (idle) sends 11111.
- R5: `sym_kind` = 2'b10 (sync) sends 11000 and then 10001 directly after it. No `sym_req` is raised at the boundary between the two halves.
- R6: `sym_kind` = 2'b11 (reserved) sends idle, 11111.
- R7: Outside test mode and outside a sync pair, `sym_req` is high for exactly one cycle in every five, namely the cycle carrying the last bit of the current group. `sym_kind` and `sym_nibble` are sampled at the clock edge that ends that cycle.
- R8: In test mode each group holds the next five bits of a generator built on x^7 + x^6 + 1. Its state s[6:0] is seeded to all ones by reset. Each step produces new = s[6] ^ s[5], shifts it in as s = {s[5:0], new}, and transmits new. The first generated bit is sent first. The state holds while test mode is off, so the sequence resumes where it stopped.
- R9: `test_en` is sampled only at group boundaries, so a change in the middle of a group does not alter that group. `sym_req` stays low while `test_en` is high.
- R10: The generator state is never all zeros.
- R11: If `test_en` rises during the first half of a sync pair, the second half (10001) is still sent complete before the test sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | Select the pseudo-random test sequence |
| sym_kind | input | 2 | Symbol type: 00 data, 01 idle, 10 sync, 11 reserved |
| sym_nibble | input | 4 | Data nibble used when the type is data |
| sym_req | output | 1 | Pulse: the next symbol is taken at the end of this cycle |
| ser_out | output | 1 | Serial line output |

## Verification
Two events can land on the same group boundary: a pending second sync half and a new test-mode request. The bench starts a sync pair and raises `test_en` one bit into the first half. It then checks that the second half still comes out as 10001, that no request appears at either boundary, and that the next group carries the next five generator bits. A second case that shares a boundary is the return from test mode. Here `test_en` is dropped in the middle of a group, and the bench checks that the remaining bits are still generator output and that the request appears exactly on that group's last bit.

// File: rtl/nlt_pkg.sv
// Package: shared symbol kinds and the nibble-to-group code table.
// Assumes 4-bit nibbles and 5-bit code groups throughout.
package nlt_pkg;

    localparam int NIB_W = 4;
    localparam int SYM_W = 5;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_IDLE = 2'b01,
        KIND_SYNC = 2'b10,
        KIND_RSVD = 2'b11
    } sym_kind_t;

    localparam logic [SYM_W-1:0] CODE_IDLE   = 5'b11111;
    localparam logic [SYM_W-1:0] CODE_SYNC_A = 5'b11000;
    localparam logic [SYM_W-1:0] CODE_SYNC_B = 5'b10001;

    // Map one data nibble to its 5-bit group.
    function automatic logic [SYM_W-1:0] nib_to_group(input logic [NIB_W-1:0] nib);
        logic [SYM_W-1:0] g;
        case (nib)
            4'h0: g = 5'b11110;
            4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;
            4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;
            4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;
            4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;
            4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;
            4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;
            4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;
            default: g = 5'b11101;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/nlt_code_mapper.sv
// Module: nlt_code_mapper
// Purely combinational. It picks the 5-bit group for the symbol the
// scheduler is offering: a data code, idle, or the first sync half.
// The second sync half is not chosen here. The top decides it from its
// own pending flag. Assumes the reserved kind is to be sent as idle.
module nlt_code_mapper
    import nlt_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [NIB_W-1:0] nibble,
    output logic [SYM_W-1:0] group
);

    // Select the group from the symbol kind.
    always_comb begin
        case (sym_kind_t'(kind))
            KIND_DATA: group = nib_to_group(nibble);
            KIND_SYNC: group = CODE_SYNC_A;
            default:   group = CODE_IDLE;
        endcase
    end

endmodule

// File: rtl/nlt_prbs_gen.sv
// Module: nlt_prbs_gen
// A 7-stage feedback shift generator (taps set by parameters) that
// advances STEPS positions on each adv pulse and returns those STEPS new
// bits, the oldest one at the MSB. Reset seeds it to all ones. Assumes
// the taps describe a maximal-length polynomial, so the state never
// reaches zero.
module nlt_prbs_gen #(
    parameter int ORDER = 7,
    parameter int TAP_A = 7,
    parameter int TAP_B = 6,
    parameter int STEPS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [STEPS-1:0] bits
);

    localparam int IA = TAP_A - 1;
    localparam int IB = TAP_B - 1;

    logic [ORDER-1:0] state;
    logic [ORDER-1:0] chain [0:STEPS];

    assign chain[0] = state;

    // Unroll STEPS generator steps per advance.
    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic nb;
        assign nb           = chain[i][IA] ^ chain[i][IB];
        assign chain[i+1]   = {chain[i][ORDER-2:0], nb};
        assign bits[STEPS-1-i] = nb;
    end

    // Hold or advance the generator state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '1;
        else if (adv)
            state <= chain[STEPS];
    end

    p_prbs_nonzero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    p_prbs_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));

endmodule

// File: rtl/nlt_shift_out.sv
// Module: nlt_shift_out
// A W-bit parallel-to-serial stage. The MSB goes out first. A bit counter
// marks the last bit of each group (at_last), and the next word is loaded
// on the edge that ends that cycle. Reset loads RST_WORD with the counter
// at zero. Assumes load_word is valid whenever at_last is high.
module nlt_shift_out #(
    parameter int              W        = 5,
    parameter logic [W-1:0]    RST_WORD = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_word,
    output logic         at_last,
    output logic         ser_out
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] cnt;

    assign at_last = (cnt == LAST);
    assign ser_out = shreg[W-1];

    // Track the bit position within the current group.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (at_last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Load a fresh group or shift the current one left.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= RST_WORD;
        else if (at_last)
            shreg <= load_word;
        else
            shreg <= {shreg[W-2:0], 1'b0};
    end

    p_shift_msb_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !at_last |=> ser_out == $past(shreg[W-2]));

    p_load_msb_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> ser_out == $past(load_word[W-1]));

    p_cnt_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/nibble_line_tx.sv
// Module: nibble_line_tx (top)
// Serial transmit end. It maps scheduler symbols to 5-bit groups, or in
// test mode takes groups from a pseudo-random source, and shifts them out
// MSB first. Requests, the test input and the second sync half are all
// decided only at group boundaries. Assumes the scheduler answers a
// request in the same cycle in which it is raised.
module nibble_line_tx
    import nlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic [1:0]       sym_kind,
    input  logic [NIB_W-1:0] sym_nibble,
    output logic             sym_req,
    output logic             ser_out
);

    logic             at_last;
    logic             k_pend;
    logic             prbs_adv;
    logic [SYM_W-1:0] map_group;
    logic [SYM_W-1:0] prbs_group;
    logic [SYM_W-1:0] next_group;

    nlt_code_mapper u_map (
        .kind   (sym_kind),
        .nibble (sym_nibble),
        .group  (map_group)
    );

    nlt_prbs_gen #(
        .ORDER (7),
        .TAP_A (7),
        .TAP_B (6),
        .STEPS (SYM_W)
    ) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (prbs_adv),
        .bits  (prbs_group)
    );

    nlt_shift_out #(
        .W        (SYM_W),
        .RST_WORD (CODE_IDLE)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_word (next_group),
        .at_last   (at_last),
        .ser_out   (ser_out)
    );

    // Decide what the boundary loads: a pending sync half first, then test, then the scheduler.
    always_comb begin
        sym_req  = 1'b0;
        prbs_adv = 1'b0;
        if (k_pend) begin
            next_group = CODE_SYNC_B;
        end else if (test_en) begin
            next_group = prbs_group;
            prbs_adv   = at_last;
        end else begin
            next_group = map_group;
            sym_req    = at_last;
        end
    end

    // Remember that the second sync half is owed at the next boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            k_pend <= 1'b0;
        else if (at_last)
            k_pend <= sym_req && (sym_kind == KIND_SYNC);
    end

    p_k_after_j_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req && sym_kind == KIND_SYNC) |=> k_pend);

    p_k_blocks_req_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        k_pend |-> !sym_req);

    p_req_gap_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        sym_req |=> !sym_req);

    p_k_first_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (k_pend && at_last) |=> ser_out);

endmodule

// File: tb/nibble_line_tx_tb_top.sv
`timescale 1ns/1ps
module nibble_line_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0;
    logic [1:0] sym_kind = 2'b01;
    logic [3:0] sym_nibble = 4'h0;
    logic       sym_req;
    logic       ser_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [6:0] pn = 7'h7F;

    always #5 clk = ~clk;

    nibble_line_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .sym_kind   (sym_kind),
        .sym_nibble (sym_nibble),
        .sym_req    (sym_req),
        .ser_out    (ser_out)
    );

    // Vector: {kind[1:0], nibble[3:0], expected group[4:0]}
    localparam int NV = 18;
    localparam logic [10:0] VEC [NV] = '{
        {2'b00, 4'h0, 5'b11110}, {2'b00, 4'h1, 5'b01001},
        {2'b00, 4'h2, 5'b10100}, {2'b00, 4'h3, 5'b10101},
        {2'b00, 4'h4, 5'b01010}, {2'b00, 4'h5, 5'b01011},
        {2'b00, 4'h6, 5'b01110}, {2'b00, 4'h7, 5'b01111},
        {2'b00, 4'h8, 5'b10010}, {2'b00, 4'h9, 5'b10011},
        {2'b00, 4'hA, 5'b10110}, {2'b00, 4'hB, 5'b10111},
        {2'b00, 4'hC, 5'b11010}, {2'b00, 4'hD, 5'b11011},
        {2'b00, 4'hE, 5'b11100}, {2'b00, 4'hF, 5'b11101},
        {2'b01, 4'h3, 5'b11111}, {2'b11, 4'h9, 5'b11111}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic pn_step();
        logic nb;
        nb = pn[6] ^ pn[5];
        pn = {pn[5:0], nb};
        return nb;
    endfunction

    // Collect five bits at the next five falling edges; also record sym_req.
    task automatic grab5(output logic [4:0] g, output logic [4:0] rq);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            g[4-i]  = ser_out;
            rq[4-i] = sym_req;
        end
    endtask

    task automatic wait_req();
        int guard = 0;
        while (!sym_req && guard < 20) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        test_en = 1'b0;
        sym_kind = 2'b01;
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b1 && sym_req == 1'b0, "R1 in reset", {ser_out, sym_req}, 2'b10);
        rst_n = 1'b1;
        pn = 7'h7F;
    endtask

    initial begin : stim
        logic [4:0] g, rq, exp_pn;
        logic b;
        do_reset();
        // R1: release cycle plus four more carry idle; request on the fifth bit.
        begin
            logic [4:0] gg, rr;
            gg[4] = ser_out; rr[4] = sym_req;
            for (int i = 1; i < 5; i++) begin
                @(negedge clk);
                gg[4-i] = ser_out; rr[4-i] = sym_req;
            end
            chk(gg == 5'b11111, "R1 first idle", gg, 5'b11111);
            chk(rr == 5'b00001, "R1 first request", rr, 5'b00001);
        end

        // R2 R4 R6 R7 R3: table walk.
        for (int k = 0; k < NV; k++) begin
            wait_req();
            sym_kind = VEC[k][10:9];
            sym_nibble = VEC[k][8:5];
            grab5(g, rq);
            chk(g == VEC[k][4:0], "R2/R4/R6 code group (R3 order)", g, VEC[k][4:0]);
            chk(rq == 5'b00001, "R7 request spacing", rq, 5'b00001);
        end

        // R5: sync pair.
        wait_req();
        sym_kind = 2'b10;
        grab5(g, rq);
        sym_kind = 2'b01;
        chk(g == 5'b11000, "R5 sync first half", g, 5'b11000);
        chk(rq == 5'b00000, "R5 no request before second half", rq, 5'b0);
        grab5(g, rq);
        chk(g == 5'b10001, "R5 sync second half", g, 5'b10001);
        chk(rq == 5'b00001, "R5 request after pair", rq, 5'b00001);

        // R9: test_en raised mid data group does not alter it.
        sym_kind = 2'b00;
        sym_nibble = 4'h5;
        @(negedge clk);
        g[4] = ser_out;
        test_en = 1'b1;
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            g[4-i] = ser_out;
            rq[4-i] = sym_req;
        end
        rq[4] = 1'b0;
        chk(g == 5'b01011, "R9 group intact on mid-group switch", g, 5'b01011);
        chk(sym_req == 1'b0, "R9 no request in test mode", sym_req, 1'b0);

        // R8: two full groups of the sequence.
        for (int j = 0; j < 2; j++) begin
            for (int i = 0; i < 5; i++) exp_pn[4-i] = pn_step();
            grab5(g, rq);
            chk(g == exp_pn, "R8 test sequence", g, exp_pn);
            chk(rq == 5'b0, "R9 no request in test", rq, 5'b0);
        end
        // R9: drop test_en two bits into the group; remainder stays test output.
        for (int i = 0; i < 5; i++) exp_pn[4-i] = pn_step();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            g[4-i] = ser_out;
            rq[4-i] = sym_req;
            if (i == 1) test_en = 1'b0;
        end
        chk(g == exp_pn, "R9 group finished after test_en drop", g, exp_pn);
        chk(rq == 5'b00001, "R9 request only at boundary", rq, 5'b00001);

        // R11: test_en rises inside the first sync half.
        sym_kind = 2'b10;
        @(negedge clk);
        g[4] = ser_out;
        test_en = 1'b1;
        sym_kind = 2'b01;
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            g[4-i] = ser_out;
        end
        chk(g == 5'b11000, "R11 first half", g, 5'b11000);
        grab5(g, rq);
        chk(g == 5'b10001, "R11 second half kept", g, 5'b10001);
        chk(rq == 5'b0, "R11 no request", rq, 5'b0);
        for (int i = 0; i < 5; i++) exp_pn[4-i] = pn_step();
        grab5(g, rq);
        chk(g == exp_pn, "R11/R8 sequence resumes", g, exp_pn);
        test_en = 1'b0;
        wait_req();
        chk(sym_req == 1'b1, "R7 request after test", sym_req, 1'b1);
        sym_kind = 2'b01;
        grab5(g, rq);
        chk(g == 5'b11111, "R4 idle after test", g, 5'b11111);

        // R1/R8/R10: mid-stream reset reseeds; long run never stalls at zero.
        @(negedge clk);
        do_reset();
        wait_req();
        test_en = 1'b1;
        for (int j = 0; j < 30; j++) begin
            for (int i = 0; i < 5; i++) exp_pn[4-i] = pn_step();
            grab5(g, rq);
            chk(g == exp_pn, "R8/R10 sequence after reseed", g, exp_pn);
        end
        b = 1'b0;
        chk(pn != 7'h00, "R10 model state", pn, 7'h7F);
        test_en = b;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule